// File: doc/BRIEF.md
# Prefix-Decoded Serial Configuration Register

This block is a write-only serial slave that collects 8-bit programming words and files the value part of each word into one of five configuration registers. The top bits of a word form a prefix code of two or three bits. A two-bit prefix leaves a 6-bit value, and a three-bit prefix leaves a 5-bit value. The registers drive the control codes of an analog signal chain: a bandpass centre-frequency code, a gain code, an integrator time-constant code, an input channel select with diagnostic mode bits, prescaler bits, and the enable of the three-state serial output driver.

The serial pins are oversampled by the block clock through two-stage synchronizers, so the serial clock must be several times slower than the block clock. A word is kept only when chip select returns high after exactly eight falling serial-clock edges, and only while the integrate/hold input reads hold (low). Every other word leaves all registers as they were.

Top module: `pfx_cfg_spi`

## Requirements
- R1: While chip select is low, one data bit is taken on each falling serial-clock edge, and the word is assembled most significant bit first.
- R2: A word commits on the rising edge of chip select only if exactly eight falling edges arrived since chip select fell and `int_hold` is low. Seven bits, nine bits, or `int_hold` high leave every output unchanged.
- R3: A committed word with bits 7:6 = 00 sets `bpf_code` to bits 5:0.
- R4: A committed word with bits 7:6 = 10 sets `gain_code` to bits 5:0.
- R5: A committed word with bits 7:5 = 110 sets `itc_code` to bits 4:0.
- R6: A committed word with bits 7:5 = 111 sets `chan_sel` to bit 0 and stores bits 4:1 as the diagnostic mode.
- R7: `diag_mode` shows the stored diagnostic bits while `run_mode` is low and reads zero while `run_mode` is high.
- R8: A committed word with bits 7:6 = 01 sets `presc` to bits 5:1 and the output-disable bit Z to bit 0.
- R9: `so_oe` is 1 only while Z = 0 and the synchronized chip select is low. Otherwise it is 0.
- R10: After reset, all codes, `chan_sel` and the diagnostic bits are zero, and Z is 1, so `so_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock; data taken on falling edges |
| sdi | input | 1 | Serial data in |
| int_hold | input | 1 | 1 = integrate, 0 = hold (writes allowed) |
| run_mode | input | 1 | 1 = run, diagnostic bits masked |
| bpf_code | output | 6 | Bandpass centre-frequency code |
| gain_code | output | 6 | Gain/attenuation code |
| itc_code | output | 5 | Integrator time-constant code |
| chan_sel | output | 1 | Input channel select |
| diag_mode | output | 4 | Effective diagnostic mode bits |
| presc | output | 5 | Prescaler bits P5..P1 |
| so_oe | output | 1 | Serial output driver enable |

## Verification
Each pin reaches the logic two clock edges after it changes. A chip-select rise therefore changes the configuration outputs on the third rising clock edge after the pin moves. `so_oe` follows a chip-select change on the second edge. `diag_mode` follows `run_mode` in the same cycle. The bench model replays this delay with a history queue of pin samples and compares every output at each falling clock edge, where the design's registers are settled. The directed checks read the outputs several cycles after each word, long after the latency has passed.

// File: rtl/pfx_cfg_pkg.sv
package pfx_cfg_pkg;
  localparam int WORD_W  = 8;
  localparam int LONG_W  = 6;
  localparam int SHORT_W = 5;
  localparam int DIAG_W  = 4;
  localparam int PRE_W   = 5;

  typedef enum logic [2:0] {T_NONE, T_BPF, T_GAIN, T_ITC, T_TEST, T_PRE} tgt_e;

  typedef struct packed {
    logic [LONG_W-1:0]  bpf;
    logic [LONG_W-1:0]  gain;
    logic [SHORT_W-1:0] itc;
    logic               chan;
    logic [DIAG_W-1:0]  diag;
    logic [PRE_W-1:0]   pre;
    logic               z;
  } cfg_t;

  function automatic cfg_t cfg_reset();
    cfg_t c;
    c   = '0;
    c.z = 1'b1;
    return c;
  endfunction

  // prefix code: 2-bit 00/10/01, 3-bit 110/111
  function automatic tgt_e decode_prefix(input logic [WORD_W-1:0] w);
    tgt_e t;
    casez (w[WORD_W-1 -: 3])
      3'b00?:  t = T_BPF;
      3'b10?:  t = T_GAIN;
      3'b01?:  t = T_PRE;
      3'b110:  t = T_ITC;
      3'b111:  t = T_TEST;
      default: t = T_NONE;
    endcase
    return t;
  endfunction

  function automatic cfg_t apply_word(input cfg_t c, input logic [WORD_W-1:0] w);
    cfg_t n;
    n = c;
    case (decode_prefix(w))
      T_BPF:  n.bpf  = w[LONG_W-1:0];
      T_GAIN: n.gain = w[LONG_W-1:0];
      T_ITC:  n.itc  = w[SHORT_W-1:0];
      T_TEST: begin
        n.chan = w[0];
        n.diag = w[DIAG_W:1];
      end
      T_PRE: begin
        n.pre = w[PRE_W:1];
        n.z   = w[0];
      end
      default: n = c;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/pfx_cfg_sync.sv
module pfx_cfg_sync #(
  parameter int          W      = 4,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= RST;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= RST;
          else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pfx_cfg_shifter.sv
module pfx_cfg_shifter
  import pfx_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  output logic [WORD_W-1:0] word,
  output logic              word_done
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic             sck_q, cs_q;
  logic [CNT_W-1:0] count;
  logic             sck_fall, cs_rise;

  assign sck_fall  = sck_q & ~sck_s;
  assign cs_rise   = ~cs_q & cs_n_s;
  assign word_done = cs_rise && (count == CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_n_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      word  <= '0;
    end else if (cs_n_s) begin
      count <= '0;
    end else if (sck_fall) begin
      word <= {word[WORD_W-2:0], sdi_s};
      if (count != CNT_SAT) count <= count + 1'b1;
    end
  end

  // R1: bit count restarts whenever chip select is inactive
  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> count == '0);
  // R1: each falling edge under select shifts the sampled bit in at the bottom
  p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && !cs_n_s) |=> word[0] == $past(sdi_s));
endmodule

// File: rtl/pfx_cfg_regs.sv
module pfx_cfg_regs
  import pfx_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic              word_done,
  input  logic              int_s,
  output cfg_t              cfg
);
  logic commit;
  assign commit = word_done & ~int_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg <= cfg_reset();
    else if (commit) cfg <= apply_word(cfg, word);

  p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> cfg == $past(cfg));
  p_bpf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[7:6] == 2'b00) |=> cfg.bpf == $past(word[5:0]));
  p_gain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[7:6] == 2'b10) |=> cfg.gain == $past(word[5:0]));
  p_itc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[7:5] == 3'b110) |=> cfg.itc == $past(word[4:0]));
  p_test_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[7:5] == 3'b111) |=> {cfg.diag, cfg.chan} == $past(word[4:0]));
  p_pre_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[7:6] == 2'b01) |=> {cfg.pre, cfg.z} == $past(word[5:0]));
endmodule

// File: rtl/pfx_cfg_spi.sv
module pfx_cfg_spi
  import pfx_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sck,
  input  logic               sdi,
  input  logic               int_hold,
  input  logic               run_mode,
  output logic [LONG_W-1:0]  bpf_code,
  output logic [LONG_W-1:0]  gain_code,
  output logic [SHORT_W-1:0] itc_code,
  output logic               chan_sel,
  output logic [DIAG_W-1:0]  diag_mode,
  output logic [PRE_W-1:0]   presc,
  output logic               so_oe
);
  localparam int SYNC_STAGES = 2;

  logic [3:0]        pins_s;
  logic              cs_n_s, sck_s, sdi_s, int_s;
  logic [WORD_W-1:0] word;
  logic              word_done;
  cfg_t              cfg;

  pfx_cfg_sync #(.W(4), .STAGES(SYNC_STAGES), .RST(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sck, sdi, int_hold}), .q(pins_s)
  );
  assign {cs_n_s, sck_s, sdi_s, int_s} = pins_s;

  pfx_cfg_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_s(sck_s), .sdi_s(sdi_s),
    .word(word), .word_done(word_done)
  );

  pfx_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .word(word), .word_done(word_done),
    .int_s(int_s), .cfg(cfg)
  );

  assign bpf_code  = cfg.bpf;
  assign gain_code = cfg.gain;
  assign itc_code  = cfg.itc;
  assign chan_sel  = cfg.chan;
  assign presc     = cfg.pre;
  assign diag_mode = run_mode ? '0 : cfg.diag;
  assign so_oe     = ~cfg.z & ~cs_n_s;

  // R9: driver never enabled while the bus is deselected
  p_oe_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && $past(cs_n_s)) |-> !so_oe);
  // R2: a word seen while integrating leaves the codes as they were
  p_int_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && int_s) |=> $stable({bpf_code, gain_code, itc_code, chan_sel, presc}));
endmodule

// File: tb/sim_pfx_cfg_spi.sv
`timescale 1ns/1ps
module sim_pfx_cfg_spi;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, int_hold = 1'b0, run_mode = 1'b0;
  logic [5:0] bpf_code, gain_code;
  logic [4:0] itc_code, presc;
  logic [3:0] diag_mode;
  logic chan_sel, so_oe;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pfx_cfg_spi u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .int_hold(int_hold), .run_mode(run_mode), .bpf_code(bpf_code),
    .gain_code(gain_code), .itc_code(itc_code), .chan_sel(chan_sel),
    .diag_mode(diag_mode), .presc(presc), .so_oe(so_oe));

  // ---------- behavioural reference model ----------
  logic [3:0] hist[$];     // {cs,sck,sdi,hold}, newest first
  int m_bpf, m_gain, m_itc, m_chan, m_diag, m_pre, m_z, m_n;
  logic [7:0] m_word;

  task automatic model_reset();
    hist = {4'b1000, 4'b1000, 4'b1000};
    m_bpf = 0; m_gain = 0; m_itc = 0; m_chan = 0; m_diag = 0; m_pre = 0;
    m_z = 1; m_n = 0; m_word = 0;
  endtask

  task automatic model_apply(input logic [7:0] w);
    int v;
    v = w;
    if (w[7:6] == 2'b00)       m_bpf  = v % 64;
    else if (w[7:6] == 2'b10)  m_gain = v % 64;
    else if (w[7:6] == 2'b01) begin m_pre = (v % 64) / 2; m_z = v % 2; end
    else if (w[5] == 1'b0)     m_itc  = v % 32;
    else begin m_chan = v % 2; m_diag = (v % 32) / 2; end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      logic [3:0] cur, prv;
      cur = hist[1]; prv = hist[2];
      if (cur[3] && !prv[3] && m_n == 8 && !cur[0]) model_apply(m_word);
      if (cur[3]) m_n = 0;
      else if (!cur[2] && prv[2]) begin
        m_word = {m_word[6:0], cur[1]};
        if (m_n < 9) m_n++;
      end
      hist.push_front({cs_n, sck, sdi, int_hold});
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3", "model bpf", bpf_code, m_bpf);
    chk("R4", "model gain", gain_code, m_gain);
    chk("R5", "model itc", itc_code, m_itc);
    chk("R6", "model chan", chan_sel, m_chan);
    chk("R7", "model diag", diag_mode, run_mode ? 0 : m_diag);
    chk("R8", "model presc", presc, m_pre);
    chk("R9", "model so_oe", so_oe, (m_z == 0 && hist[1][3] == 1'b0) ? 1 : 0);
  end

  // ---------- stimulus ----------
  localparam int HALF = 4;

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] bits, input int nbits);
    @(negedge clk); cs_n = 1'b0; wait_n(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = bits[i]; sck = 1'b1; wait_n(HALF);
      sck = 1'b0; wait_n(HALF);
    end
    cs_n = 1'b1; wait_n(8);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_n(5); rst_n = 1'b1; wait_n(3);
    chk("R10", "reset bpf", bpf_code, 0);
    chk("R10", "reset diag/chan", {diag_mode, chan_sel}, 0);
    chk("R10", "reset so_oe", so_oe, 0);

    send(16'h000A, 8); chk("R1", "bpf 0x0A msb-first", bpf_code, 10);
    send(16'h0094, 8); chk("R4", "gain 0x94", gain_code, 20);
    send(16'h00C3, 8); chk("R5", "itc 0xC3", itc_code, 3);
    send(16'h00E9, 8); chk("R6", "chan 0xE9", chan_sel, 1);
    chk("R7", "diag visible test", diag_mode, 4);
    run_mode = 1'b1; wait_n(1);
    chk("R7", "diag masked run", diag_mode, 0);
    run_mode = 1'b0;
    send(16'h003F, 8); chk("R3", "bpf 0x3F", bpf_code, 63);
    chk("R3", "gain untouched", gain_code, 20);

    send(16'h0040, 8); chk("R8", "presc 0x40", presc, 0);
    chk("R9", "so_oe off while deselected", so_oe, 0);
    @(negedge clk); cs_n = 1'b0; wait_n(4);
    chk("R9", "so_oe on with z=0", so_oe, 1);
    cs_n = 1'b1; wait_n(4);
    chk("R9", "so_oe off after deselect", so_oe, 0);

    send(16'h0015, 7);  chk("R2", "7-bit word dropped", bpf_code, 63);
    send(16'h0115, 9);  chk("R2", "9-bit word dropped", {bpf_code, gain_code}, {6'd63, 6'd20});
    int_hold = 1'b1;
    send(16'h0081, 8);  chk("R2", "write during integrate dropped", gain_code, 20);
    int_hold = 1'b0;

    send(16'h007F, 8); chk("R8", "presc 0x7F", presc, 31);
    @(negedge clk); cs_n = 1'b0; wait_n(4);
    chk("R9", "so_oe off with z=1", so_oe, 0);
    cs_n = 1'b1; wait_n(6);
    send(16'h00FE, 8); chk("R6", "chan 0 diag 15", {diag_mode, chan_sel}, 30);
    send(16'h00DF, 8); chk("R5", "itc 31", itc_code, 31);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule